// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block joins two 18-bit ports, A and B, with one storage path for each direction. Each path has four controls: a pass control, a strobe, an active-low strobe enable and an active-low drive enable. While the pass control is high, the path is transparent and its output follows its input in the same cycle. While the pass control is low, the path shows what it last stored, and it only takes new data on a qualified rising strobe. The drive enable sets an output-valid flag, which stands in for a tri-state driver. A wrapper above the block can turn the flag and the data into a real bus pin.

The whole block runs on one fast system clock. Each direction's strobe is sampled every system cycle, and a rising edge is found by comparing the current sample with the previous one, so no latch and no second clock domain are built. The two directions share only the system clock and the reset. Each cycle, a path loads in one of three ways:

- LOAD_FLOW: the pass control is high, so the register reloads from the input.
- LOAD_EDGE: a qualified strobe rise occurs while the pass control is low, so the input is captured.
- LOAD_HOLD: neither applies, so the register keeps its value.

Top module: `duplex_bus_xcvr`

## Requirements
- R1: The data path is 18 bits wide and does not invert: every output bit equals the input bit it was passed or stored from, with bit n mapping to bit n.
- R2: While `ab_pass` is high, `b_out` equals `a_in` in the same cycle.
- R3: While `ab_pass` is low and there is no qualified strobe rise, `b_out` keeps its value whatever `a_in` does, and whether `ab_strobe` rests high or low.
- R4: A qualified strobe rise is a system clock edge at which `ab_strobe` is sampled 1, its sample at the previous edge was 0, `ab_pass` is 0 and `ab_strobe_en_n` is 0. At that edge `a_in` is stored, and it appears on `b_out` from the next cycle on.
- R5: While `ab_strobe_en_n` is 1, a rising `ab_strobe` stores nothing.
- R6: `b_oe` is 1 when `ab_drive_n` is 0 and 0 when `ab_drive_n` is 1, outside reset. `b_out` carries the stored or passed data either way.
- R7: When `ab_pass` falls, storage keeps the `a_in` value sampled at the last system clock edge with `ab_pass` high.
- R8: The B-to-A path (`b_in`, `ba_*` controls, `a_out`, `a_oe`) obeys R2 to R7 with its own controls, independently of the A-to-B path.
- R9: While `rst_n` is low, `a_oe` and `b_oe` are 0. Each clock edge with `rst_n` low clears both storage registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Data received from port A |
| a_out | output | 18 | Data toward port A (B-to-A path) |
| a_oe | output | 1 | Port A drive flag, 0 means high impedance |
| b_in | input | 18 | Data received from port B |
| b_out | output | 18 | Data toward port B (A-to-B path) |
| b_oe | output | 1 | Port B drive flag, 0 means high impedance |
| ab_pass | input | 1 | A-to-B transparent control, active high |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_drive_n | input | 1 | A-to-B drive enable, active low |
| ba_pass | input | 1 | B-to-A transparent control, active high |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |

## Verification
Directed patterns come first:

- An alternating-bit word passed transparently checks for bit swaps and inversion.
- Dropping the pass control while the input changes separates "keeps the last passed value" from "follows the input".
- A strobe rise with the enable low, set against the same rise with the enable high, tells capture apart from blocked capture.
- A strobe held high across input changes shows that a level does not count as an edge.

Random sequences then drive the pass, strobe, enable and drive controls of both paths and resets at the same time. This shows whether one path's controls ever disturb the other path's storage or flag.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    parameter int unsigned XCVR_W = 18;
    localparam int unsigned XCVR_LANES = 2;

    typedef enum logic [1:0] {
        LOAD_HOLD = 2'd0,
        LOAD_FLOW = 2'd1,
        LOAD_EDGE = 2'd2
    } load_kind_e;

endpackage

// File: rtl/xcvr_edge_sense.sv
module xcvr_edge_sense (
    input  logic clk,
    input  logic strobe,
    input  logic strobe_en_n,
    input  logic pass,
    output logic fire
);

    logic strobe_prev;

    // The previous sample is tracked in every cycle, reset included,
    // so a strobe that is already high when reset ends is not an edge.
    always_ff @(posedge clk) begin
        strobe_prev <= strobe;
    end

    assign fire = strobe & ~strobe_prev & ~strobe_en_n & ~pass;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         pass,
    input  logic         strobe,
    input  logic         strobe_en_n,
    input  logic         drive_n,
    output logic [W-1:0] dout,
    output logic         oe
);

    logic         fire;
    load_kind_e   load_kind;
    logic [W-1:0] store_q;
    logic [W-1:0] store_d;

    xcvr_edge_sense u_edge (
        .clk         (clk),
        .strobe      (strobe),
        .strobe_en_n (strobe_en_n),
        .pass        (pass),
        .fire        (fire)
    );

    always_comb begin
        if (pass) begin
            load_kind = LOAD_FLOW;
        end else if (fire) begin
            load_kind = LOAD_EDGE;
        end else begin
            load_kind = LOAD_HOLD;
        end
    end

    always_comb begin
        unique case (load_kind)
            LOAD_FLOW: store_d = din;
            LOAD_EDGE: store_d = din;
            LOAD_HOLD: store_d = store_q;
            default:   store_d = store_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign dout = pass ? din : store_q;
    assign oe   = rst_n & ~drive_n;

endmodule

// File: rtl/duplex_bus_xcvr.sv
module duplex_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ab_strobe_en_n,
    input  logic         ab_drive_n,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic         ba_strobe_en_n,
    input  logic         ba_drive_n
);

    localparam int unsigned N = XCVR_LANES;

    logic [N-1:0][W-1:0] lane_din;
    logic [N-1:0][W-1:0] lane_dout;
    logic [N-1:0]        lane_pass;
    logic [N-1:0]        lane_strobe;
    logic [N-1:0]        lane_strobe_en_n;
    logic [N-1:0]        lane_drive_n;
    logic [N-1:0]        lane_oe;

    // lane 0 carries A to B, lane 1 carries B to A
    assign lane_din[0]         = a_in;
    assign lane_din[1]         = b_in;
    assign lane_pass           = {ba_pass, ab_pass};
    assign lane_strobe         = {ba_strobe, ab_strobe};
    assign lane_strobe_en_n    = {ba_strobe_en_n, ab_strobe_en_n};
    assign lane_drive_n        = {ba_drive_n, ab_drive_n};

    for (genvar g = 0; g < N; g++) begin : g_lane
        xcvr_lane #(.W(W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .din         (lane_din[g]),
            .pass        (lane_pass[g]),
            .strobe      (lane_strobe[g]),
            .strobe_en_n (lane_strobe_en_n[g]),
            .drive_n     (lane_drive_n[g]),
            .dout        (lane_dout[g]),
            .oe          (lane_oe[g])
        );
    end

    assign b_out = lane_dout[0];
    assign b_oe  = lane_oe[0];
    assign a_out = lane_dout[1];
    assign a_oe  = lane_oe[1];

endmodule

// File: rtl/duplex_bus_xcvr_chk.sv
module duplex_bus_xcvr_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ab_pass,
    input logic         ab_strobe,
    input logic         ab_strobe_en_n,
    input logic         ba_pass,
    input logic         ba_strobe,
    input logic         ba_strobe_en_n
);

    logic [1:0] age     = '0;
    logic       was_rst = 1'b0;
    logic       ab_cp_d = 1'b0;
    logic       ba_cp_d = 1'b0;
    logic       armed;
    logic       ab_qual;
    logic       ba_qual;

    always_ff @(posedge clk) begin
        ab_cp_d <= ab_strobe;
        ba_cp_d <= ba_strobe;
        was_rst <= !rst_n;
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign armed   = (age >= 2'd2);
    assign ab_qual = ab_strobe & ~ab_cp_d & ~ab_strobe_en_n & ~ab_pass;
    assign ba_qual = ba_strobe & ~ba_cp_d & ~ba_strobe_en_n & ~ba_pass;

    AST_AB_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ab_pass |-> (b_out == a_in)); // R2

    AST_AB_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!ab_pass && $past(!ab_pass) && !$past(ab_qual)) |-> $stable(b_out)); // R3

    AST_AB_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ab_qual |=> (ab_pass || (b_out == $past(a_in)))); // R4

    AST_BA_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ba_pass |-> (a_out == b_in)); // R8

    AST_BA_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ba_qual |=> (ba_pass || (a_out == $past(b_in)))); // R8

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_FLAGS_OFF: assert (!a_oe && !b_oe); // R9
        end
        if (was_rst && rst_n && !ab_pass) begin
            AST_RST_STORE_ZERO: assert (b_out == '0); // R9
        end
    end

endmodule

bind duplex_bus_xcvr duplex_bus_xcvr_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .a_in           (a_in),
    .a_out          (a_out),
    .a_oe           (a_oe),
    .b_in           (b_in),
    .b_out          (b_out),
    .b_oe           (b_oe),
    .ab_pass        (ab_pass),
    .ab_strobe      (ab_strobe),
    .ab_strobe_en_n (ab_strobe_en_n),
    .ba_pass        (ba_pass),
    .ba_strobe      (ba_strobe),
    .ba_strobe_en_n (ba_strobe_en_n)
);

// File: tb/duplex_bus_xcvr_test.sv
module duplex_bus_xcvr_test;

    localparam int W      = 18;
    localparam int PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_pass, ab_strobe, ab_strobe_en_n, ab_drive_n;
    logic         ba_pass, ba_strobe, ba_strobe_en_n, ba_drive_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_ab_store = '0, m_ba_store = '0;
    logic         m_ab_prev = 1'b0, m_ba_prev = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    duplex_bus_xcvr #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe),
        .ab_strobe_en_n(ab_strobe_en_n), .ab_drive_n(ab_drive_n),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe),
        .ba_strobe_en_n(ba_strobe_en_n), .ba_drive_n(ba_drive_n)
    );

    function automatic logic [W-1:0] exp_data(logic pass, logic [W-1:0] din,
                                              logic [W-1:0] store);
        return pass ? din : store;
    endfunction

    function automatic logic [W-1:0] next_store(logic rst, logic pass, logic cp,
                                                logic prev, logic en_n,
                                                logic [W-1:0] din,
                                                logic [W-1:0] store);
        if (!rst) return '0;
        if (pass) return din;
        if (cp && !prev && !en_n) return din;
        return store;
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Check outputs away from the edge, then advance the model at the edge.
    task automatic step(string tag_ab, string tag_ba);
        string t_ab, t_ba;
        #1;
        t_ab = (tag_ab != "") ? tag_ab : (!rst_n ? "R9" : (ab_pass ? "R2" : "R3"));
        t_ba = (tag_ba != "") ? tag_ba : (!rst_n ? "R9" : "R8");
        if (rst_n) begin
            chk(t_ab, "b_out", b_out, exp_data(ab_pass, a_in, m_ab_store));
            chk(t_ba, "a_out", a_out, exp_data(ba_pass, b_in, m_ba_store));
        end
        chk(rst_n ? "R6" : "R9", "b_oe", {{(W-1){1'b0}}, b_oe},
            {{(W-1){1'b0}}, rst_n & ~ab_drive_n});
        chk(rst_n ? "R8" : "R9", "a_oe", {{(W-1){1'b0}}, a_oe},
            {{(W-1){1'b0}}, rst_n & ~ba_drive_n});
        @(posedge clk);
        m_ab_store = next_store(rst_n, ab_pass, ab_strobe, m_ab_prev, ab_strobe_en_n, a_in, m_ab_store);
        m_ba_store = next_store(rst_n, ba_pass, ba_strobe, m_ba_prev, ba_strobe_en_n, b_in, m_ba_store);
        m_ab_prev  = ab_strobe;
        m_ba_prev  = ba_strobe;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_pass = 1'b0; ab_strobe = 1'b0; ab_strobe_en_n = 1'b1; ab_drive_n = 1'b1;
        ba_pass = 1'b0; ba_strobe = 1'b0; ba_strobe_en_n = 1'b1; ba_drive_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R9", "R9");
        rst_n = 1'b1;
        step("R9", "R9");                    // storage cleared, visible as zero

        // R1 / R2: alternating bits pass straight through, port driven
        ab_drive_n = 1'b0; ab_pass = 1'b1; a_in = 18'h2AAAA;
        step("R1", "");
        a_in = 18'h15555;
        step("R2", "");
        // R7: pass falls while input changes; last passed value kept
        ab_pass = 1'b0; a_in = 18'h3F00F;
        step("R7", "");
        step("R7", "");
        // R4: qualified rising strobe captures
        ab_strobe_en_n = 1'b0; ab_strobe = 1'b1; a_in = 18'h0C3A5;
        step("R4", "");
        a_in = 18'h11111;                    // strobe held high: no new edge
        step("R3", "");
        ab_strobe = 1'b0;
        step("R3", "");
        // R5: rising strobe with enable inactive stores nothing
        ab_strobe_en_n = 1'b1; ab_strobe = 1'b1; a_in = 18'h22222;
        step("R5", "");
        step("R5", "");
        // R6: drive off, data still present
        ab_drive_n = 1'b1;
        step("R6", "");
        // R8: B-to-A capture while A-to-B holds
        ba_drive_n = 1'b0; ba_strobe_en_n = 1'b0; b_in = 18'h2D2D2; ba_strobe = 1'b1;
        step("R3", "R8");
        b_in = 18'h00001;
        step("R3", "R8");

        for (int c = 0; c < RAND_CYCLES; c++) begin
            rst_n          = ($urandom_range(199) != 0);
            a_in           = W'($urandom);
            b_in           = W'($urandom);
            ab_pass        = ($urandom_range(3) == 0);
            ba_pass        = ($urandom_range(3) == 0);
            ab_strobe      = ($urandom_range(1) == 0) ? ~ab_strobe : ab_strobe;
            ba_strobe      = ($urandom_range(1) == 0) ? ~ba_strobe : ba_strobe;
            ab_strobe_en_n = ($urandom_range(9) >= 6);
            ba_strobe_en_n = ($urandom_range(9) >= 6);
            ab_drive_n     = $urandom_range(1);
            ba_drive_n     = $urandom_range(1);
            step("", "");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule